// File: doc/BRIEF.md
# Character-Oriented Synchronous Serial Receiver

This block takes a bit-serial stream on `rx_bit`. The stream is sampled only on clock cycles where `bit_en` is high. The receiver starts in a hunt phase. It stays there until one of three synchronisation rules succeeds:

- an 8-bit sync character is matched;
- a 12-bit or 16-bit sync pattern is matched;
- the external `ext_sync` input is seen.

After that the receiver is in a framing phase. It packs every further group of eight bits into a character. It pushes each character into a four-entry receive queue. The host drains the queue with a valid/ready handshake.

A message is `msg_len` characters long, and the last two of them are the CRC bytes. The receiver runs a CRC-16 over every framed bit. When the last character of a message is written, its queue entry carries two flags: an end-of-message flag, and a CRC-error flag taken from the residual. The error status therefore reaches the host in the same entry as the data it belongs to. The host can pulse `hunt_req` at any time to drop synchronisation and search again.

The controller has two named states:

- `ST_HUNT`: searching for synchronisation.
- `ST_FRAME`: assembling characters.

It has three named transitions:

- `sync_found`: `ST_HUNT` to `ST_FRAME`, on a pattern match or on an external sync.
- `hunt_cmd`: any state to `ST_HUNT`, on `hunt_req`.
- `frame_hold`: `ST_FRAME` stays in `ST_FRAME` otherwise.

Top module: `sync_char_rx`

## Requirements
- R1: After reset, `in_sync` is 0, `rd_valid` is 0 and `overrun` is 0.
- R2: With `mode`=00 (single character), synchronisation is declared on the bit-enable cycle that completes the last 8 received bits equal to `sync_pat[7:0]`. The earliest received of those bits is bit 0. `in_sync` is 1 from the next cycle on. The sync bits are never written to the queue.
- R3: With `mode`=01 and `long_sync`=1, the same rule applies to the last 16 bits against `sync_pat[15:0]`.
- R4: With `mode`=01 and `long_sync`=0, the same rule applies to the last 12 bits against `sync_pat[11:0]`. `sync_pat[15:12]` is ignored.
- R5: With `mode`=10 or 11 (external), no pattern is compared. The bit sampled on the bit-enable cycle where `ext_sync` is 1 during hunt is bit 0 of the first character. In the pattern modes `ext_sync` has no effect.
- R6: Characters are assembled least-significant bit first. A character is pushed on the bit-enable cycle of its eighth bit, and `rd_valid` rises on the next cycle.
- R7: Character number `msg_len` of a message is flagged `rd_eom`=1, counting from 1 after sync. Its `rd_crc_err` is 1 exactly when the CRC-16 residual is non-zero. The CRC uses polynomial x^16+x^15+x^2+1, processed bit-serially LSB first, reflected constant 0xA001, preset 0. On such data the residual is zero when the two CRC bytes are sent low byte first. The CRC and the character count then restart for the next message. `rd_crc_err` is 0 on all other entries.
- R8: The queue holds 4 entries and is read in order. While `rd_valid`=1 and `rd_ready`=0, the head entry does not change.
- R9: A character that completes while the queue is full is dropped and sets `overrun`. `overrun` stays 1 until `hunt_req` or reset.
- R10: `hunt_req` makes `in_sync` 0 on the next cycle and clears the CRC, the character count and the sync shift register. The queue contents are kept. Bits received afterwards are not framed until a new synchronisation.
- R11: Cycles with `bit_en`=0 shift nothing and cannot cause synchronisation, even when `ext_sync` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_en | input | 1 | Receive bit strobe; `rx_bit` is sampled when high |
| rx_bit | input | 1 | Serial data in |
| mode | input | 2 | 00 single character, 01 long pattern, 1x external |
| long_sync | input | 1 | In mode 01: 1 selects a 16-bit pattern, 0 selects a 12-bit pattern |
| sync_pat | input | 16 | Sync pattern, bit 0 received first |
| ext_sync | input | 1 | External start-of-field marker |
| msg_len | input | 8 | Characters per message, including both CRC bytes (at least 3) |
| hunt_req | input | 1 | Pulse: drop sync and hunt again |
| rd_ready | input | 1 | Host accepts the head entry |
| rd_valid | output | 1 | Queue not empty |
| rd_data | output | 8 | Head character |
| rd_crc_err | output | 1 | Head entry ends a message with a CRC mismatch |
| rd_eom | output | 1 | Head entry is the last character of a message |
| overrun | output | 1 | Sticky queue overrun flag |
| in_sync | output | 1 | Receiver is framing characters |

## Verification
The hardest case to reach from the ports is a re-hunt in the middle of a message. After it, the CRC and the character count must both start from zero, while an orphan character is still waiting in the queue. The bench reaches this case in one sequence:

1. It synchronises and sends one character of a three-character message.
2. It pulses `hunt_req`.
3. It sends all-ones bits, which cannot match the sync pattern.
4. It synchronises again and sends a complete, correct message.

The end-of-message flag must then fall on the third new entry with no CRC error. It must also appear after the orphan entry. The bench also checks that a sync pattern seen without `ext_sync` does not synchronise in external mode.

// File: rtl/sync_rx_pkg.sv
package sync_rx_pkg;

    localparam int CHAR_W = 8;

    typedef enum logic {
        ST_HUNT  = 1'b0,
        ST_FRAME = 1'b1
    } rx_state_t;

    typedef struct packed {
        logic              eom;
        logic              crc_err;
        logic [CHAR_W-1:0] data;
    } rx_entry_t;

endpackage

// File: rtl/sync_rx_hunt.sv
module sync_rx_hunt #(
    parameter int SYNC_W  = 16,
    parameter int MONO_W  = 8,
    parameter int SHORT_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              shift_en,
    input  logic              bit_in,
    input  logic              mono_sel,
    input  logic              long_sel,
    input  logic [SYNC_W-1:0] pat,
    output logic              match
);

    logic [SYNC_W-1:0] win_q;
    logic [SYNC_W-1:0] win_n;

    // newest bit enters at the top, so the oldest bit of a window sits lowest
    assign win_n = {bit_in, win_q[SYNC_W-1:1]};

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            win_q <= '0;
        end else if (shift_en) begin
            win_q <= win_n;
        end
    end

    always_comb begin
        if (mono_sel) begin
            match = (win_n[SYNC_W-1 -: MONO_W] == pat[MONO_W-1:0]);
        end else if (long_sel) begin
            match = (win_n == pat);
        end else begin
            match = (win_n[SYNC_W-1 -: SHORT_W] == pat[SHORT_W-1:0]);
        end
    end

endmodule

// File: rtl/sync_rx_crc.sv
module sync_rx_crc #(
    parameter int          CRC_W = 16,
    parameter logic [15:0] POLY  = 16'hA001
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             step,
    input  logic             bit_in,
    output logic [CRC_W-1:0] crc_next
);

    logic [CRC_W-1:0] crc_q;
    logic             fb;

    always_comb begin
        fb       = crc_q[0] ^ bit_in;
        crc_next = {1'b0, crc_q[CRC_W-1:1]};
        if (fb) begin
            crc_next = crc_next ^ POLY[CRC_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            crc_q <= '0;
        end else if (step) begin
            crc_q <= crc_next;
        end
    end

endmodule

// File: rtl/sync_rx_fifo.sv
module sync_rx_fifo
    import sync_rx_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      push,
    input  rx_entry_t wr_entry,
    input  logic      pop,
    input  logic      ovr_clr,
    output logic      not_empty,
    output rx_entry_t rd_entry,
    output logic      ovr
);

    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    rx_entry_t        mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [PTR_W:0]   count;
    logic             full, do_push, do_pop;

    assign full      = (count == (PTR_W+1)'(DEPTH));
    assign not_empty = (count != '0);
    assign do_push   = push && !full;
    assign do_pop    = pop && not_empty;
    assign rd_entry  = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (do_push) begin
            mem[wr_ptr] <= wr_entry;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) begin
                wr_ptr <= (wr_ptr == PTR_W'(DEPTH-1)) ? '0 : wr_ptr + 1'b1;
            end
            if (do_pop) begin
                rd_ptr <= (rd_ptr == PTR_W'(DEPTH-1)) ? '0 : rd_ptr + 1'b1;
            end
            count <= count + (PTR_W+1)'(do_push) - (PTR_W+1)'(do_pop);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n || ovr_clr) begin
            ovr <= 1'b0;
        end else if (push && full) begin
            ovr <= 1'b1;
        end
    end

endmodule

// File: rtl/sync_char_rx.sv
module sync_char_rx
    import sync_rx_pkg::*;
#(
    parameter int SYNC_W     = 16,
    parameter int MSG_W      = 8,
    parameter int FIFO_DEPTH = 4,
    parameter int CRC_W      = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_en,
    input  logic              rx_bit,
    input  logic [1:0]        mode,
    input  logic              long_sync,
    input  logic [SYNC_W-1:0] sync_pat,
    input  logic              ext_sync,
    input  logic [MSG_W-1:0]  msg_len,
    input  logic              hunt_req,
    input  logic              rd_ready,
    output logic              rd_valid,
    output logic [CHAR_W-1:0] rd_data,
    output logic              rd_crc_err,
    output logic              rd_eom,
    output logic              overrun,
    output logic              in_sync
);

    localparam int BIT_W = $clog2(CHAR_W);

    rx_state_t         state_q, state_d;
    logic              is_ext, hunting;
    logic              pat_match, ext_start, sync_found;
    logic              take_bit, char_done, msg_last;
    logic [BIT_W-1:0]  bit_cnt;
    logic [CHAR_W-1:0] char_sh, char_val;
    logic [MSG_W-1:0]  byte_cnt;
    logic [CRC_W-1:0]  crc_next;
    logic              crc_clr;
    rx_entry_t         wr_entry, rd_entry;

    assign is_ext     = mode[1];
    assign hunting    = (state_q == ST_HUNT);
    assign ext_start  = hunting && is_ext && bit_en && ext_sync && !hunt_req;
    assign sync_found = hunting && bit_en && !hunt_req &&
                        (is_ext ? ext_sync : pat_match);
    assign take_bit   = bit_en && !hunt_req && (!hunting || ext_start);
    assign char_done  = take_bit && (bit_cnt == BIT_W'(CHAR_W-1));
    assign char_val   = {rx_bit, char_sh[CHAR_W-1:1]};
    assign msg_last   = (byte_cnt == msg_len - 1'b1);
    assign crc_clr    = hunt_req || (hunting && !ext_start) ||
                        (char_done && msg_last);

    // next state: sync_found, hunt_cmd, frame_hold
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HUNT:  if (sync_found) state_d = ST_FRAME;
            ST_FRAME: state_d = ST_FRAME;
        endcase
        if (hunt_req) begin
            state_d = ST_HUNT;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_HUNT;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        in_sync = (state_q == ST_FRAME);
    end

    always_ff @(posedge clk) begin
        if (!rst_n || hunt_req || (hunting && !ext_start)) begin
            bit_cnt  <= '0;
            byte_cnt <= '0;
            char_sh  <= '0;
        end else if (take_bit) begin
            char_sh <= char_val;
            bit_cnt <= bit_cnt + 1'b1;
            if (char_done) begin
                byte_cnt <= msg_last ? '0 : byte_cnt + 1'b1;
            end
        end
    end

    always_comb begin
        wr_entry.data    = char_val;
        wr_entry.eom     = msg_last;
        wr_entry.crc_err = msg_last && (crc_next != '0);
    end

    sync_rx_hunt #(
        .SYNC_W (SYNC_W)
    ) u_hunt (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (hunt_req || !hunting),
        .shift_en (hunting && bit_en && !hunt_req),
        .bit_in   (rx_bit),
        .mono_sel (mode == 2'b00),
        .long_sel (long_sync),
        .pat      (sync_pat),
        .match    (pat_match)
    );

    sync_rx_crc #(
        .CRC_W (CRC_W)
    ) u_crc (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (crc_clr),
        .step     (take_bit),
        .bit_in   (rx_bit),
        .crc_next (crc_next)
    );

    sync_rx_fifo #(
        .DEPTH (FIFO_DEPTH)
    ) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (char_done),
        .wr_entry  (wr_entry),
        .pop       (rd_ready),
        .ovr_clr   (hunt_req),
        .not_empty (rd_valid),
        .rd_entry  (rd_entry),
        .ovr       (overrun)
    );

    assign rd_data    = rd_entry.data;
    assign rd_eom     = rd_entry.eom;
    assign rd_crc_err = rd_entry.crc_err;

endmodule

// File: rtl/sync_char_rx_chk.sv
module sync_char_rx_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       bit_en,
    input logic       ext_sync,
    input logic [1:0] mode,
    input logic       hunt_req,
    input logic       rd_ready,
    input logic       rd_valid,
    input logic [7:0] rd_data,
    input logic       rd_crc_err,
    input logic       rd_eom,
    input logic       overrun,
    input logic       in_sync
);

    assert_hunt_drops_sync_R10: assert property (@(posedge clk) disable iff (!rst_n)
        hunt_req |=> !in_sync);

    assert_sync_needs_strobe_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(in_sync) |-> $past(bit_en));

    assert_ext_sync_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(in_sync) && $past(mode[1])) |-> $past(ext_sync));

    assert_head_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data) &&
                                     $stable(rd_eom) && $stable(rd_crc_err)));

    assert_overrun_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (overrun && !hunt_req) |=> overrun);

    assert_err_with_eom_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && rd_crc_err) |-> rd_eom);

endmodule

bind sync_char_rx sync_char_rx_chk u_chk (.*);

// File: tb/sync_char_rx_bench.sv
module sync_char_rx_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bit_en = 1'b0;
    logic        rx_bit = 1'b0;
    logic [1:0]  mode = 2'b00;
    logic        long_sync = 1'b0;
    logic [15:0] sync_pat = 16'h0016;
    logic        ext_sync = 1'b0;
    logic [7:0]  msg_len = 8'd4;
    logic        hunt_req = 1'b0;
    logic        rd_ready = 1'b0;
    logic        rd_valid;
    logic [7:0]  rd_data;
    logic        rd_crc_err;
    logic        rd_eom;
    logic        overrun;
    logic        in_sync;

    int n_chk = 0;
    int n_bad = 0;
    bit ext_arm = 1'b0;

    always #10 clk = ~clk;

    sync_char_rx u_sync_char_rx (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .rx_bit(rx_bit),
        .mode(mode), .long_sync(long_sync), .sync_pat(sync_pat),
        .ext_sync(ext_sync), .msg_len(msg_len), .hunt_req(hunt_req),
        .rd_ready(rd_ready), .rd_valid(rd_valid), .rd_data(rd_data),
        .rd_crc_err(rd_crc_err), .rd_eom(rd_eom), .overrun(overrun),
        .in_sync(in_sync)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] crc_byte(input logic [15:0] c, input logic [7:0] d);
        for (int i = 0; i < 8; i++) begin
            logic fb;
            fb = c[0] ^ d[i];
            c  = c >> 1;
            if (fb) c = c ^ 16'hA001;
        end
        return c;
    endfunction

    task automatic send_bit(input logic b);
        @(negedge clk);
        rx_bit   = b;
        bit_en   = 1'b1;
        ext_sync = ext_arm;
        ext_arm  = 1'b0;
        @(negedge clk);
        bit_en   = 1'b0;
        ext_sync = 1'b0;
        rx_bit   = ~b;
    endtask

    task automatic send_bits(input logic [15:0] v, input int n);
        for (int i = 0; i < n; i++) send_bit(v[i]);
    endtask

    task automatic send_frame(input logic [7:0] d0, input logic [7:0] d1, input int n,
                              input bit corrupt, output logic [15:0] crc_tx);
        logic [15:0] c;
        c = crc_byte(16'h0000, d0);
        send_bits({8'h00, d0}, 8);
        if (n > 1) begin
            c = crc_byte(c, d1);
            send_bits({8'h00, d1}, 8);
        end
        if (corrupt) c = c ^ 16'h0100;
        crc_tx = c;
        send_bits({8'h00, c[7:0]}, 8);
        send_bits({8'h00, c[15:8]}, 8);
    endtask

    task automatic pop_expect(input logic [7:0] d, input logic eom, input logic err,
                              input string req);
        chk(rd_valid === 1'b1, {req, " valid"}, rd_valid, 1);
        chk(rd_data === d, {req, " data"}, rd_data, d);
        chk(rd_eom === eom, {req, " eom"}, rd_eom, eom);
        chk(rd_crc_err === err, {req, " crc_err"}, rd_crc_err, err);
        rd_ready = 1'b1;
        @(negedge clk);
        rd_ready = 1'b0;
    endtask

    task automatic do_hunt();
        @(negedge clk);
        hunt_req = 1'b1;
        @(negedge clk);
        hunt_req = 1'b0;
        chk(in_sync === 1'b0, "R10 hunt clears sync", in_sync, 0);
    endtask

    task automatic t_reset();
        chk(in_sync === 1'b0, "R1 in_sync", in_sync, 0);
        chk(rd_valid === 1'b0, "R1 rd_valid", rd_valid, 0);
        chk(overrun === 1'b0, "R1 overrun", overrun, 0);
    endtask

    task automatic t_mono();
        logic [15:0] c;
        mode = 2'b00; sync_pat = 16'h0016; msg_len = 8'd4;
        send_bits(16'h0005, 3);
        send_bits(16'h0016, 7);
        chk(in_sync === 1'b0, "R2 no sync before last bit", in_sync, 0);
        send_bit(1'b0);
        chk(in_sync === 1'b1, "R2 sync on char match", in_sync, 1);
        chk(rd_valid === 1'b0, "R2 sync char not queued", rd_valid, 0);
        send_frame(8'hA5, 8'h3C, 2, 1'b0, c);
        pop_expect(8'hA5, 1'b0, 1'b0, "R6 lsb first");
        pop_expect(8'h3C, 1'b0, 1'b0, "R6 second char");
        pop_expect(c[7:0], 1'b0, 1'b0, "R7 crc low");
        pop_expect(c[15:8], 1'b1, 1'b0, "R7 good crc eom");
        chk(rd_valid === 1'b0, "R6 queue drained", rd_valid, 0);
        send_frame(8'h5A, 8'hC3, 2, 1'b1, c);
        pop_expect(8'h5A, 1'b0, 1'b0, "R7 restart data");
        pop_expect(8'hC3, 1'b0, 1'b0, "R7 restart data2");
        pop_expect(c[7:0], 1'b0, 1'b0, "R7 bad crc low");
        pop_expect(c[15:8], 1'b1, 1'b1, "R7 crc mismatch flagged");
    endtask

    task automatic t_bi16();
        logic [15:0] c;
        do_hunt();
        mode = 2'b01; long_sync = 1'b1; sync_pat = 16'hB2C7; msg_len = 8'd3;
        send_bits(16'hB2C7, 15);
        chk(in_sync === 1'b0, "R3 no sync at 15 bits", in_sync, 0);
        send_bit(1'b1);
        chk(in_sync === 1'b1, "R3 sync on 16-bit match", in_sync, 1);
        send_frame(8'h7E, 8'h00, 1, 1'b0, c);
        pop_expect(8'h7E, 1'b0, 1'b0, "R3 data");
        pop_expect(c[7:0], 1'b0, 1'b0, "R3 crc low");
        pop_expect(c[15:8], 1'b1, 1'b0, "R3 eom");
    endtask

    task automatic t_bi12();
        logic [15:0] c;
        do_hunt();
        mode = 2'b01; long_sync = 1'b0; sync_pat = 16'hFA53; msg_len = 8'd3;
        send_bits(16'h0A53, 11);
        chk(in_sync === 1'b0, "R4 no sync at 11 bits", in_sync, 0);
        send_bit(1'b1);
        chk(in_sync === 1'b1, "R4 sync on 12-bit match", in_sync, 1);
        send_frame(8'h81, 8'h00, 1, 1'b0, c);
        pop_expect(8'h81, 1'b0, 1'b0, "R4 data");
        pop_expect(c[7:0], 1'b0, 1'b0, "R4 crc low");
        pop_expect(c[15:8], 1'b1, 1'b0, "R4 eom");
    endtask

    task automatic t_ext();
        logic [15:0] c;
        do_hunt();
        mode = 2'b00; sync_pat = 16'h0016; msg_len = 8'd3;
        ext_arm = 1'b1;
        send_bits(16'h0000, 8);
        chk(in_sync === 1'b0, "R5 ext_sync ignored in pattern mode", in_sync, 0);
        do_hunt();
        mode = 2'b10;
        send_bits(16'h0016, 8);
        chk(in_sync === 1'b0, "R5 pattern ignored in external mode", in_sync, 0);
        @(negedge clk);
        ext_sync = 1'b1;
        @(negedge clk);
        ext_sync = 1'b0;
        chk(in_sync === 1'b0, "R11 ext_sync without strobe", in_sync, 0);
        ext_arm = 1'b1;
        send_frame(8'h42, 8'h00, 1, 1'b0, c);
        chk(in_sync === 1'b1, "R5 external sync", in_sync, 1);
        pop_expect(8'h42, 1'b0, 1'b0, "R5 first bit on ext_sync");
        pop_expect(c[7:0], 1'b0, 1'b0, "R5 crc low");
        pop_expect(c[15:8], 1'b1, 1'b0, "R5 eom");
    endtask

    task automatic t_overrun();
        do_hunt();
        mode = 2'b00; sync_pat = 16'h0016; msg_len = 8'd200;
        send_bits(16'h0016, 8);
        send_bits(16'h0011, 8);
        chk(rd_data === 8'h11, "R8 head", rd_data, 8'h11);
        send_bits(16'h0022, 8);
        send_bits(16'h0033, 8);
        send_bits(16'h0044, 8);
        chk(overrun === 1'b0, "R9 no overrun at 4", overrun, 0);
        send_bits(16'h0055, 8);
        chk(overrun === 1'b1, "R9 overrun set", overrun, 1);
        chk(rd_data === 8'h11, "R8 head held while full", rd_data, 8'h11);
        pop_expect(8'h11, 1'b0, 1'b0, "R8 order 1");
        pop_expect(8'h22, 1'b0, 1'b0, "R8 order 2");
        pop_expect(8'h33, 1'b0, 1'b0, "R8 order 3");
        pop_expect(8'h44, 1'b0, 1'b0, "R8 order 4");
        chk(rd_valid === 1'b0, "R9 fifth char dropped", rd_valid, 0);
        chk(overrun === 1'b1, "R9 overrun sticky", overrun, 1);
        do_hunt();
        chk(overrun === 1'b0, "R9 hunt clears overrun", overrun, 0);
    endtask

    task automatic t_rehunt();
        logic [15:0] c;
        mode = 2'b00; sync_pat = 16'h0016; msg_len = 8'd3;
        send_bits(16'h0016, 8);
        send_bits(16'h0099, 8);
        do_hunt();
        send_bits(16'h00FF, 8);
        chk(in_sync === 1'b0, "R10 no framing after hunt", in_sync, 0);
        send_bits(16'h0016, 8);
        send_frame(8'h24, 8'h00, 1, 1'b0, c);
        pop_expect(8'h99, 1'b0, 1'b0, "R10 queue kept");
        pop_expect(8'h24, 1'b0, 1'b0, "R10 new message");
        pop_expect(c[7:0], 1'b0, 1'b0, "R10 crc low");
        pop_expect(c[15:8], 1'b1, 1'b0, "R10 count and crc restarted");
        chk(rd_valid === 1'b0, "R10 nothing extra", rd_valid, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_mono();
        t_bi16();
        t_bi12();
        t_ext();
        t_overrun();
        t_rehunt();
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule